// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition-Code Register

This block joins a purely combinational arithmetic/logic datapath to an eight-bit registered condition-code word. The datapath takes two operands and a four-bit operation code. It returns a result in the same cycle. It covers addition, subtraction, increment, decrement, the four bitwise operations, single-position logical and arithmetic shifts, and single-position rotates.

When `flag_we` is high, the status flags are loaded on the next rising clock edge. The status flags are carry, overflow, negative, zero and a BCD half-carry. The same register also holds two interrupt-mask bits and a stop-disable bit. These three control bits are written only through a separate enable and data port.

A sequencer drives the operation code and operands each cycle. It raises `flag_we` for the instructions whose flags must be kept. It then reads the condition-code word to decide branches.

Top module: `alu_ccr`

## Requirements
- R1: Operation code 0 (add) gives result = a+b modulo 2^W. C is the carry out of the top bit. H is the carry out of bit 3. V is set when the two's-complement sum falls outside the signed range.
- R2: Code 1 (subtract) gives result = a-b modulo 2^W. C is set when b > a unsigned (borrow). H is set when the low nibble of b exceeds the low nibble of a. V is set when the signed difference is out of range.
- R3: Code 2 (increment) gives a+1 and code 3 (decrement) gives a-1, both wrapping. H is set when the increment carries out of bit 3, or when the decrement borrows into bit 3. V flags a signed wrap. C is left unchanged.
- R4: Codes 4, 5, 6 and 7 give a AND b, a OR b, a XOR b and NOT a. V is cleared, and C and H are left unchanged.
- R5: Shifts move the operand one position. Codes 8 (logical left) and 12 (arithmetic left) both give a<<1. Code 9 fills bit W-1 with 0. Code 13 copies the old sign bit into bit W-1. C receives the bit shifted out. V is the XOR of a's two top bits for left shifts and 0 for right shifts. H is unchanged.
- R6: Codes 10 and 11 rotate a left or right by one. C receives the bit that wrapped around, V is cleared, and H is unchanged.
- R7: For every code 0 to 13, N is loaded with the result's top bit, and Z is set exactly when the result is all zeros.
- R8: The status bits (C at bit 0, V bit 1, Z bit 2, N bit 3, H bit 5) change only on a rising edge with `flag_we` high. Otherwise they hold.
- R9: With `ctl_we` high, `ctl_din[2:0]` is loaded into stop-disable (bit 7), mask1 (bit 6) and mask0 (bit 4). This happens independently of `flag_we`. With `ctl_we` low these bits hold.
- R10: Synchronous reset sets the condition-code word to 0x50. All status flags are clear, both masks are set and stop-disable is clear.
- R11: Reserved codes 14 and 15 pass a to the result and leave every status flag unchanged, even with `flag_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Load status flags on this edge |
| ctl_we | input | 1 | Load control bits on this edge |
| ctl_din | input | 3 | {stop-disable, mask1, mask0} |
| result | output | W | Combinational result |
| ccr | output | 8 | Condition-code word |

## Verification
Every operation code is applied with every value of the first operand. Each of these is paired with sixteen second operands spread across the byte (multiples of 17). This set hits each carry and half-carry boundary, signed overflow in both directions, sign-bit fill and wrap-around.

The flag enable is dropped on a rotating subset of vectors. This shows that held flags differ from freshly computed ones. It also makes the preserved C and H values depend on earlier operations.

Control writes interleave with status writes, which separates the two fields. Reserved codes are applied after flags were set non-zero, so that an unintended update is visible.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_INC = 4'd2,  OP_DEC = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_NOT = 4'd7,
    OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
    OP_SAL = 4'd12, OP_SAR = 4'd13, OP_RS0 = 4'd14, OP_RS1 = 4'd15
  } alu_op_e;

  localparam int CCR_W  = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_V  = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_N  = 3;
  localparam int BIT_M0 = 4;
  localparam int BIT_H  = 5;
  localparam int BIT_M1 = 6;
  localparam int BIT_SD = 7;
  localparam logic [CCR_W-1:0] CCR_RST = 8'h50;
endpackage

// File: rtl/alu_arith.sv
module alu_arith import alu_ccr_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o,
  output logic         c_upd
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_op_e     opc;
  logic        is_sub;
  logic        is_step;
  logic [W-1:0] op2;
  logic [W-1:0] op2_eff;
  logic [W:0]   wide;
  logic [4:0]   nib;

  assign opc     = alu_op_e'(op);
  assign is_step = (opc == OP_INC) || (opc == OP_DEC);
  assign is_sub  = (opc == OP_SUB) || (opc == OP_DEC);
  assign op2     = is_step ? ONE : b;
  assign op2_eff = is_sub ? ~op2 : op2;

  always_comb begin
    if (is_sub) begin
      wide = {1'b0, a} - {1'b0, op2};
      nib  = {1'b0, a[3:0]} - {1'b0, op2[3:0]};
    end else begin
      wide = {1'b0, a} + {1'b0, op2};
      nib  = {1'b0, a[3:0]} + {1'b0, op2[3:0]};
    end
    res   = wide[W-1:0];
    c_o   = wide[W];
    h_o   = nib[4];
    v_o   = (a[W-1] == op2_eff[W-1]) && (wide[W-1] != a[W-1]);
    c_upd = !is_step;
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops import alu_ccr_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         c_o,
  output logic         v_o,
  output logic         c_upd
);
  alu_op_e opc;
  assign opc = alu_op_e'(op);

  always_comb begin
    res   = a;
    c_o   = 1'b0;
    v_o   = 1'b0;
    c_upd = 1'b1;
    unique case (opc)
      OP_AND: begin res = a & b; c_upd = 1'b0; end
      OP_OR:  begin res = a | b; c_upd = 1'b0; end
      OP_XOR: begin res = a ^ b; c_upd = 1'b0; end
      OP_NOT: begin res = ~a;    c_upd = 1'b0; end
      OP_SHL, OP_SAL: begin
        res = {a[W-2:0], 1'b0};
        c_o = a[W-1];
        v_o = a[W-1] ^ a[W-2];
      end
      OP_SHR: begin res = {1'b0, a[W-1:1]};    c_o = a[0];   end
      OP_SAR: begin res = {a[W-1], a[W-1:1]};  c_o = a[0];   end
      OP_ROL: begin res = {a[W-2:0], a[W-1]};  c_o = a[W-1]; end
      OP_ROR: begin res = {a[0], a[W-1:1]};    c_o = a[0];   end
      default: begin res = a; c_upd = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg import alu_ccr_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_we,
  input  logic             c_i,
  input  logic             v_i,
  input  logic             z_i,
  input  logic             n_i,
  input  logic             h_i,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_din,
  output logic [CCR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= CCR_RST;
    end else begin
      if (st_we) begin
        q[BIT_C] <= c_i;
        q[BIT_V] <= v_i;
        q[BIT_Z] <= z_i;
        q[BIT_N] <= n_i;
        q[BIT_H] <= h_i;
      end
      if (ctl_we) begin
        q[BIT_SD] <= ctl_din[2];
        q[BIT_M1] <= ctl_din[1];
        q[BIT_M0] <= ctl_din[0];
      end
    end
  end

  logic [4:0] st_view;
  logic [2:0] ctl_view;
  assign st_view  = {q[BIT_H], q[BIT_N], q[BIT_Z], q[BIT_V], q[BIT_C]};
  assign ctl_view = {q[BIT_SD], q[BIT_M1], q[BIT_M0]};

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_we |=> $stable(st_view));
  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(ctl_view));
  // R9
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ctl_view == $past(ctl_din));
  // R10
  reset_value_chk: assert property (@(posedge clk)
    rst |=> q == CCR_RST);
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr import alu_ccr_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [3:0]       op_sel,
  input  logic             flag_we,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_din,
  output logic [W-1:0]     result,
  output logic [CCR_W-1:0] ccr
);
  localparam logic [3:0] LAST_ARITH = 4'(OP_DEC);
  localparam logic [3:0] LAST_VALID = 4'(OP_SAR);

  logic [W-1:0] ar_res, bo_res;
  logic ar_c, ar_h, ar_v, ar_cu;
  logic bo_c, bo_v, bo_cu;
  logic sel_arith, op_valid;
  logic c_n, h_n, v_n;

  alu_arith #(.W(W)) u_arith (
    .a(opnd_a), .b(opnd_b), .op(op_sel),
    .res(ar_res), .c_o(ar_c), .h_o(ar_h), .v_o(ar_v), .c_upd(ar_cu)
  );

  alu_bitops #(.W(W)) u_bitops (
    .a(opnd_a), .b(opnd_b), .op(op_sel),
    .res(bo_res), .c_o(bo_c), .v_o(bo_v), .c_upd(bo_cu)
  );

  assign sel_arith = (op_sel <= LAST_ARITH);
  assign op_valid  = (op_sel <= LAST_VALID);

  always_comb begin
    if (!op_valid)      result = opnd_a;
    else if (sel_arith) result = ar_res;
    else                result = bo_res;
  end

  always_comb begin
    if (sel_arith) begin
      c_n = ar_cu ? ar_c : ccr[BIT_C];
      h_n = ar_h;
      v_n = ar_v;
    end else begin
      c_n = bo_cu ? bo_c : ccr[BIT_C];
      h_n = ccr[BIT_H];
      v_n = bo_v;
    end
  end

  ccr_reg u_ccr (
    .clk(clk), .rst(rst),
    .st_we(flag_we && op_valid),
    .c_i(c_n), .v_i(v_n), .z_i(result == '0), .n_i(result[W-1]), .h_i(h_n),
    .ctl_we(ctl_we), .ctl_din(ctl_din),
    .q(ccr)
  );

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel <= LAST_VALID) |=> ccr[BIT_Z] == ($past(result) == '0));
  // R7
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel <= LAST_VALID) |=> ccr[BIT_N] == $past(result[W-1]));
  // R11
  reserved_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel > LAST_VALID) |-> result == opnd_a);
  // R11
  reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel > LAST_VALID && !ctl_we) |=> ccr == $past(ccr));
endmodule

// File: tb/test_alu_ccr.sv
`timescale 1ns/1ps
module test_alu_ccr;
  logic clk = 1'b0;
  logic rst;
  logic [7:0] a, b;
  logic [3:0] op;
  logic fwe, cwe;
  logic [2:0] cdin;
  logic [7:0] res, ccr;

  int nchk = 0;
  int nbad = 0;
  logic [7:0] m_ccr;

  always #4 clk = ~clk;

  alu_ccr #(.W(8)) i_alu_ccr (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .op_sel(op),
    .flag_we(fwe), .ctl_we(cwe), .ctl_din(cdin), .result(res), .ccr(ccr)
  );

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string req_of(input int o);
    case (o)
      0: return "R1";  1: return "R2";  2, 3: return "R3";
      4, 5, 6, 7: return "R4";
      8, 9, 12, 13: return "R5";
      10, 11: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h (a=%02h b=%02h op=%0d)", tag, got, exp, a, b, op);
    end
  endtask

  task automatic step(input int ta, input int tb, input int top, input bit tf,
                      input bit tc, input int td);
    int r, c, h, v, sx, ia, ib;
    logic [7:0] nx;
    ia = ta; ib = tb;
    @(negedge clk);
    a = 8'(ta); b = 8'(tb); op = 4'(top); fwe = tf; cwe = tc; cdin = 3'(td);
    c = m_ccr[0]; h = m_ccr[5]; v = 0; r = ia;
    case (top)
      0: begin sx = sgn(ia) + sgn(ib); r = (ia + ib) % 256; c = int'(ia + ib > 255);
               h = int'((ia % 16) + (ib % 16) > 15); v = int'(sx > 127 || sx < -128); end
      1: begin sx = sgn(ia) - sgn(ib); r = (ia - ib + 256) % 256; c = int'(ia < ib);
               h = int'((ia % 16) < (ib % 16)); v = int'(sx > 127 || sx < -128); end
      2: begin r = (ia + 1) % 256; h = int'(ia % 16 == 15); v = int'(sgn(ia) + 1 > 127); end
      3: begin r = (ia + 255) % 256; h = int'(ia % 16 == 0); v = int'(sgn(ia) - 1 < -128); end
      4: r = ia & ib;
      5: r = ia | ib;
      6: r = ia ^ ib;
      7: r = 255 - ia;
      8, 12: begin r = (ia * 2) % 256; c = ia / 128; sx = sgn(ia) * 2;
                   v = int'(sx > 127 || sx < -128); end
      9:  begin r = ia / 2; c = ia % 2; end
      13: begin r = ia / 2 + (ia / 128) * 128; c = ia % 2; end
      10: begin r = (ia * 2) % 256 + ia / 128; c = ia / 128; end
      11: begin r = ia / 2 + (ia % 2) * 128; c = ia % 2; end
      default: r = ia;
    endcase
    #1;
    check8(res, 8'(r), req_of(top));
    nx = m_ccr;
    if (tf && top < 14) begin
      nx[0] = c[0]; nx[1] = v[0]; nx[2] = (r == 0); nx[3] = (r >= 128); nx[5] = h[0];
    end
    if (tc) begin nx[7] = td[2]; nx[6] = td[1]; nx[4] = td[0]; end
    m_ccr = nx;
    @(posedge clk); #1;
    if (tc)              check8(ccr, m_ccr, "R9");
    else if (!tf)        check8(ccr, m_ccr, "R8");
    else if (top >= 14)  check8(ccr, m_ccr, "R11");
    else                 check8(ccr, m_ccr, {req_of(top), "/R7"});
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    rst = 1'b1; a = '0; b = '0; op = '0; fwe = 0; cwe = 0; cdin = '0;
    m_ccr = 8'h50;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8(ccr, 8'h50, "R10");
    rst = 1'b0;
    // R9: control bits written alone and together with status
    step(0, 0, 0, 0, 1, 3'b101);
    step(200, 100, 0, 1, 1, 3'b010);
    step(5, 5, 0, 0, 1, 3'b111);
    // R11: set flags non-zero, then reserved codes with flag_we high
    step(255, 1, 0, 1, 0, 0);
    step(128, 0, 14, 1, 0, 0);
    step(3, 77, 15, 1, 0, 0);
    step(255, 255, 0, 1, 0, 0);
    step(0, 9, 15, 1, 0, 0);
    // R1..R8 sweep
    for (int o = 0; o < 14; o++)
      for (int ia = 0; ia < 256; ia++)
        for (int k = 0; k < 16; k++)
          step(ia, k * 17, o, ((ia + k + o) % 5) != 0,
               (ia == k * 17), (ia + o) % 8);
    // R10: reset again after activity
    @(negedge clk); rst = 1'b1; fwe = 0; cwe = 0;
    @(posedge clk); #1; rst = 1'b0; m_ccr = 8'h50;
    check8(ccr, 8'h50, "R10");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule